// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter for a microcontroller-style peripheral set. It counts one of two things. In timer mode it counts cycles of an internal instruction-cycle enable. In counter mode it counts edges of an external input, and software chooses whether the rising or the falling edge is counted. A programmable power-of-two prescaler can sit between the chosen source and the counter, or it can be bypassed so that every source event advances the count by one.

Software reaches the block through a small register port. A write strobe carries a 2-bit address and 8 bits of data. A combinational read port takes its own address. When the count rolls over from its maximum value to zero, a sticky overflow flag is set. The interrupt request output is high only when that flag, its own enable and a global enable are all set. After software writes a new count value, counting is held off for two instruction cycles.

Top module: `tick_counter8`

Register map. An address not listed here reads 0 and ignores writes.

- Address 0 is the count register.
- Address 1 is the configuration register:
  - bit 0 selects the external source (1 selects it);
  - bit 1 selects the falling edge (1 selects it);
  - bit 2 turns the prescaler on (1 turns it on);
  - bits 5:3 hold the ratio code n.
- Address 2 is the interrupt register:
  - bit 0 is the overflow flag;
  - bit 1 is the overflow enable;
  - bit 2 is the global enable.

## Requirements
- R1: After reset the count, configuration and interrupt registers all read 0, and `irq` is low. This state means internal source, rising edge and no prescaler.
- R2: With the internal source and the prescaler off, the count rises by exactly one on each clock where `cyc_en` is high and no inhibit is pending. It holds on every other clock.
- R3: A write to address 0 loads `wr_data` into the count on that edge. No increment then happens until two clocks with `cyc_en` high have passed. Clocks without `cyc_en` do not shorten this hold.
- R4: With bit 2 of the configuration register set, the count advances once per 2^(n+1) source events, where n is the value in bits 5:3. The prescaler count restarts from zero on any write to address 0 or address 1.
- R5: With bit 0 of the configuration register set, `ext_in` passes through two synchronizer flops and then an edge detector. A selected edge applied before clock edge k increments the count at edge k+2. The edge that is not selected, and `cyc_en`, do not increment the count.
- R6: An increment from 0xFF to 0x00 sets the overflow flag, whatever the two enables hold. Loading 0xFF through the write port does not set the flag.
- R7: The flag is cleared only by a write to address 2 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is high exactly when the flag, the overflow enable and the global enable are all 1.
- R9: Reads return the register contents as laid out in the map above, with unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle enable, used as the internal count source |
| ext_in | input | 1 | External count input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the count moves by exactly one on an increment pulse and holds otherwise;
- no increment passes while a post-write inhibit is pending, and a count write always arms that inhibit;
- an overflow event always leaves the flag set, and the flag can drop only after a clearing write;
- `irq` never rises without the flag.

Some behaviours only the bench scenarios can show. These are the exact 2^(n+1) prescale spacing and its restart, the three-edge latency from `ext_in` to the count, the choice between rising and falling edges, the two-cycle hold measured in `cyc_en` cycles, and the read-back layout. The bench covers them with directed cases and with a long random run that is compared against a model written from the requirements.

// File: rtl/tc8_pkg.sv
package tc8_pkg;

  // Register addresses on the write and read ports.
  typedef enum logic [1:0] {
    ADR_COUNT = 2'd0,
    ADR_CFG   = 2'd1,
    ADR_IRQ   = 2'd2,
    ADR_NONE  = 2'd3
  } tc8_addr_e;

  // Bit positions inside the configuration register.
  localparam int CFG_EXT_BIT  = 0;
  localparam int CFG_FALL_BIT = 1;
  localparam int CFG_PRE_BIT  = 2;
  localparam int CFG_SEL_LSB  = 3;

  // Terminal prescaler count for ratio code n, which gives a ratio of 2^(n+1).
  function automatic int ps_terminal(input int n);
    return (2 << n) - 1;
  endfunction

  // Next count value on an increment; wraps to zero past all-ones.
  function automatic int count_next(input int cur, input int width);
    return (cur + 1) % (1 << width);
  endfunction

endpackage

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops followed by one history flop.
  logic [STAGES:0] sh_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("tc8_edge_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tc8_prescaler.sv
module tc8_prescaler
  import tc8_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic             use_pre,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);
  localparam int PS_W = 1 << SEL_W;

  logic [PS_W-1:0] pc_q;
  logic [PS_W-1:0] limit;
  logic            at_top;

  assign limit  = PS_W'(ps_terminal(int'(sel)));
  assign at_top = (pc_q == limit);
  assign pulse  = evt & (~use_pre | at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pc_q <= '0;
    else if (clr)           pc_q <= '0;
    else if (evt & use_pre) pc_q <= at_top ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/tick_counter8.sv
module tick_counter8
  import tc8_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PS_SEL_W    = 3,
  parameter int INH_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       ext_in,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int CFG_W = CFG_SEL_LSB + PS_SEL_W;
  localparam int INH_W = $clog2(INH_CYC + 1);

  // Register state
  logic [DATA_W-1:0] count_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [INH_W-1:0]  inh_q;
  logic              flag_q, ovf_en_q, glob_en_q;

  // Named internal events, brought out for the checker
  logic wr_cnt, wr_cfg, wr_irq;
  logic inh_active, src_evt, gated_evt, inc_pulse, ovf_evt;
  logic ext_rise, ext_fall;

  assign wr_cnt = wr_en && (wr_addr == ADR_COUNT);
  assign wr_cfg = wr_en && (wr_addr == ADR_CFG);
  assign wr_irq = wr_en && (wr_addr == ADR_IRQ);

  tc8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_in),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  assign inh_active = (inh_q != '0);
  assign src_evt    = cfg_q[CFG_EXT_BIT]
                      ? (cfg_q[CFG_FALL_BIT] ? ext_fall : ext_rise)
                      : cyc_en;
  assign gated_evt  = src_evt & ~inh_active;

  tc8_prescaler #(.SEL_W(PS_SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (wr_cnt | wr_cfg),
    .evt    (gated_evt),
    .use_pre(cfg_q[CFG_PRE_BIT]),
    .sel    (cfg_q[CFG_SEL_LSB +: PS_SEL_W]),
    .pulse  (inc_pulse)
  );

  assign ovf_evt = inc_pulse & ~wr_cnt & (count_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (wr_cnt)    count_q <= wr_data[DATA_W-1:0];
    else if (inc_pulse) count_q <= DATA_W'(count_next(int'(count_q), DATA_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    inh_q <= '0;
    else if (wr_cnt)               inh_q <= INH_W'(INH_CYC);
    else if (cyc_en && inh_active) inh_q <= inh_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      ovf_en_q  <= 1'b0;
      glob_en_q <= 1'b0;
    end else begin
      if (ovf_evt)                    flag_q <= 1'b1;
      else if (wr_irq && !wr_data[0]) flag_q <= 1'b0;
      if (wr_irq) begin
        ovf_en_q  <= wr_data[1];
        glob_en_q <= wr_data[2];
      end
    end
  end

  always_comb begin
    case (tc8_addr_e'(rd_addr))
      ADR_COUNT: rd_data = 8'(count_q);
      ADR_CFG:   rd_data = 8'(cfg_q);
      ADR_IRQ:   rd_data = {5'b0, glob_en_q, ovf_en_q, flag_q};
      default:   rd_data = '0;
    endcase
  end

  assign irq = flag_q & ovf_en_q & glob_en_q;
endmodule

// File: rtl/tc8_checker.sv
module tc8_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cnt,
  input logic              wr_irq,
  input logic [7:0]        wr_data,
  input logic              inc_pulse,
  input logic              inh_active,
  input logic              ovf_evt,
  input logic [DATA_W-1:0] count_q,
  input logic              flag_q,
  input logic              irq
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pulse && !wr_cnt) |=> count_q == $past(count_q) + DATA_W'(1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_pulse && !wr_cnt) |=> $stable(count_q));

  p_inhibit_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inh_active |-> !inc_pulse);

  p_write_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> inh_active);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_irq && !wr_data[0])) |=> flag_q);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
endmodule

bind tick_counter8 tc8_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_cnt    (wr_cnt),
  .wr_irq    (wr_irq),
  .wr_data   (wr_data),
  .inc_pulse (inc_pulse),
  .inh_active(inh_active),
  .ovf_evt   (ovf_evt),
  .count_q   (count_q),
  .flag_q    (flag_q),
  .irq       (irq)
);

// File: tb/test_tick_counter8.sv
module test_tick_counter8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_in = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_counter8 i_tick_counter8 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_in(ext_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // ---------------- reference model, built from the requirements -------------
  logic [7:0] m_cnt, m_cfg, m_pc;
  logic [2:0] m_hist;      // [0],[1] synchronizer stages, [2] previous value
  int         m_inh;
  logic       m_flag, m_en, m_glob;

  function automatic logic [7:0] ratio_top(input logic [2:0] n);
    return 8'((1 << (int'(n) + 1)) - 1);
  endfunction

  always @(posedge clk) begin
    logic rs, fl, src, ev, pul, inc, ovf;
    if (!rst_n) begin
      m_cnt = 0; m_cfg = 0; m_pc = 0; m_hist = 0; m_inh = 0;
      m_flag = 0; m_en = 0; m_glob = 0;
    end else begin
      rs = m_hist[1] & ~m_hist[2];
      fl = ~m_hist[1] & m_hist[2];
      m_hist = {m_hist[1:0], ext_in};
      src = m_cfg[0] ? (m_cfg[1] ? fl : rs) : cyc_en;
      ev  = src && (m_inh == 0);
      pul = 0;
      if (ev) begin
        if (!m_cfg[2]) pul = 1;
        else if (m_pc == ratio_top(m_cfg[5:3])) begin pul = 1; m_pc = 0; end
        else m_pc = m_pc + 1;
      end
      if (cyc_en && m_inh != 0) m_inh = m_inh - 1;
      inc = pul && !(wr_en && wr_addr == 2'd0);
      ovf = inc && (m_cnt == 8'hFF);
      if (inc) m_cnt = m_cnt + 1;
      if (wr_en && wr_addr == 2'd0) begin m_cnt = wr_data; m_inh = 2; m_pc = 0; end
      if (wr_en && wr_addr == 2'd1) begin m_cfg = wr_data & 8'h3F; m_pc = 0; end
      if (ovf) m_flag = 1;
      else if (wr_en && wr_addr == 2'd2 && !wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 2'd2) begin m_en = wr_data[1]; m_glob = wr_data[2]; end
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return m_cfg;
      2'd2:    return {5'b0, m_glob, m_en, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  // ---------------- helpers -------------------------------------------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  // ---------------- watchdog ------------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ------------------------------------------------
  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5EED_0C08);
    step(3);
    rst_n = 1;
    // R1 reset state
    rd_chk("R1 count", 2'd0, 8'h00);
    rd_chk("R1 cfg",   2'd1, 8'h00);
    rd_chk("R1 irqreg",2'd2, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 no count without cyc_en, one per cyc_en
    step(5);
    rd_chk("R2 idle", 2'd0, 8'h00);
    cyc_en = 1; step(5);
    rd_chk("R2 five cycles", 2'd0, 8'h05);

    // R3 write then two held cycles
    wr(2'd0, 8'h10);
    rd_chk("R3 loaded", 2'd0, 8'h10);
    step(2);
    rd_chk("R3 held", 2'd0, 8'h10);
    step(1);
    rd_chk("R3 resumes", 2'd0, 8'h11);
    cyc_en = 0;
    wr(2'd0, 8'h20);
    step(3);
    cyc_en = 1; step(2);
    rd_chk("R3 hold counts cyc_en only", 2'd0, 8'h20);
    step(1);
    rd_chk("R3 after hold", 2'd0, 8'h21);

    // R6 overflow with enables off
    wr(2'd0, 8'hFE);
    step(3);
    rd_chk("R6 at FF", 2'd0, 8'hFF);
    rd_chk("R6 no flag from write", 2'd2, 8'h00);
    step(1);
    rd_chk("R6 wrapped", 2'd0, 8'h00);
    rd_chk("R6 flag set", 2'd2, 8'h01);
    chk("R8 irq off, enables clear", {7'b0, irq}, 8'h00);

    // R7 / R8 enable combinations
    wr(2'd2, 8'h03);
    rd_chk("R7 write 1 keeps flag", 2'd2, 8'h03);
    chk("R8 no global", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'h05);
    chk("R8 no own enable", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'h07);
    chk("R8 all set", {7'b0, irq}, 8'h01);
    wr(2'd2, 8'h06);
    rd_chk("R7 cleared by zero", 2'd2, 8'h06);
    chk("R8 drops with flag", {7'b0, irq}, 8'h00);

    // R4 prescaler 1:4
    wr(2'd1, 8'h0C);
    rd_chk("R9 cfg readback", 2'd1, 8'h0C);
    wr(2'd0, 8'h00);
    step(5);
    rd_chk("R4 before fourth event", 2'd0, 8'h00);
    step(1);
    rd_chk("R4 first prescaled step", 2'd0, 8'h01);
    step(4);
    rd_chk("R4 second prescaled step", 2'd0, 8'h02);

    // R5 external rising edge, latency three edges
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h40);
    step(4);
    rd_chk("R5 cyc_en ignored", 2'd0, 8'h40);
    ext_in = 1; step(2);
    rd_chk("R5 not yet", 2'd0, 8'h40);
    step(1);
    rd_chk("R5 rising counted", 2'd0, 8'h41);
    ext_in = 0; step(4);
    rd_chk("R5 falling ignored", 2'd0, 8'h41);
    wr(2'd1, 8'h03);
    ext_in = 1; step(4);
    rd_chk("R5 rising ignored", 2'd0, 8'h41);
    ext_in = 0; step(2);
    rd_chk("R5 falling pending", 2'd0, 8'h41);
    step(1);
    rd_chk("R5 falling counted", 2'd0, 8'h42);
    rd_chk("R9 unused address", 2'd3, 8'h00);

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] d;
      rd_addr = 2'($urandom_range(0, 3)); #1;
      chk("R2 random read", rd_data, model_read(rd_addr));
      chk("R8 random irq", {7'b0, irq}, {7'b0, m_flag & m_en & m_glob});
      cyc_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) == 0) ext_in = ~ext_in;
      wr_en = ($urandom_range(0, 11) == 0);
      wr_addr = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (wr_addr == 2'd0 && d[0]) d = d | 8'hF0;
      if (wr_addr == 2'd1 && d[7]) d[5:4] = 2'b00;
      wr_data = d;
      @(negedge clk);
    end
    wr_en = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule